// File: doc/BRIEF.md
# Packed Pairwise Horizontal Adder

This block takes two packed vectors, each of several equal-width lanes, and forms one packed result of the same length. The lower half of the result carries the sums of neighbouring lane pairs of the first operand, and the upper half carries the same pair sums for the second operand. Because both operands feed the result, no output lanes are wasted, even though each pair sum halves the number of elements drawn from a single operand.

Internally the work is split into two stages. A shuffle stage regroups the lanes into an "even" vector and an "odd" vector. A vertical stage then adds those two vectors lane by lane. A mode input can bypass the adder and present the two shuffled vectors directly. In that case the even vector appears on one output bus and the odd vector on the other. All outputs are registered, and a valid flag follows the input valid with one cycle of latency.

Top module: `hadd_pair_top`

## Requirements
- R1: After reset, `outValid` is 0 and both `outLo` and `outHi` are 0.
- R2: `outValid` equals the value that `inValid` had on the previous rising clock edge. Latency is exactly one cycle.
- R3: With `modeShuf`=0, lane k of `outLo` (bits 16k+15:16k) for k < LANES/2 equals opA lane 2k plus opA lane 2k+1, taken modulo 2^16.
- R4: With `modeShuf`=0, lane LANES/2+k of `outLo` equals opB lane 2k plus opB lane 2k+1, taken modulo 2^16. Any carry out of a lane is discarded and does not reach the next lane.
- R5: With `modeShuf`=0, `outHi` is all zeros.
- R6: With `modeShuf`=1, lane 2k of `outLo` equals opA lane 2k, and lane 2k+1 of `outLo` equals opB lane 2k. This is the even interleave.
- R7: With `modeShuf`=1, lane 2k of `outHi` equals opA lane 2k+1, and lane 2k+1 of `outHi` equals opB lane 2k+1. This is the odd interleave.
- R8: While `inValid` is 0, `outLo` and `outHi` keep their previous values, whatever `opA`, `opB` and `modeShuf` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and mode are valid this cycle |
| modeShuf | input | 1 | 0 selects the pairwise sum, 1 selects the raw interleave |
| opA | input | 128 | First operand, 8 lanes of 16 bits, lane 0 in the LSBs |
| opB | input | 128 | Second operand, 8 lanes of 16 bits, lane 0 in the LSBs |
| outValid | output | 1 | Registered result valid |
| outLo | output | 128 | Sum vector, or even interleave vector |
| outHi | output | 128 | Zero in sum mode, odd interleave vector in shuffle mode |

## Verification
The in-RTL assertions check the following on every cycle:
- the one-cycle valid pipeline;
- that both outputs hold when no operand is accepted;
- that the upper bus is zero after a sum-mode capture;
- that one sample lane pair matches the registered operands.

The full lane mapping, the wrap-around of carries at lane boundaries, and the placement of the second operand's sums in the upper half can only be shown by the bench. It compares both buses against model functions under random operands and directed carry and all-ones patterns.

// File: rtl/hadd_pkg.sv
package hadd_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 16;
  localparam int VEC_W  = LANES * LANE_W;

  typedef struct packed {
    logic capture;
    logic sumSel;
  } haddCtl_t;
endpackage

// File: rtl/hadd_ctrl.sv
module hadd_ctrl
  import hadd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     modeShuf,
  output haddCtl_t ctl,
  output logic     outValid
);
  always_comb begin
    ctl.capture = inValid;
    ctl.sumSel  = ~modeShuf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
endmodule

// File: rtl/hadd_datapath.sv
module hadd_datapath
  import hadd_pkg::*;
#(
  parameter int NLANE = LANES,
  parameter int LW    = LANE_W,
  localparam int W    = NLANE * LW,
  localparam int HALF = NLANE / 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  haddCtl_t     ctl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] outLo,
  output logic [W-1:0] outHi
);
  logic [W-1:0] evenVec, oddVec, sumVec, nextLo, nextHi;

  // Shuffle stage: regroup pairs so each sum partner sits in the same lane.
  for (genvar p = 0; p < HALF; p++) begin : g_shuf
    assign evenVec[(2*p)*LW   +: LW] = opA[(2*p)*LW   +: LW];
    assign evenVec[(2*p+1)*LW +: LW] = opB[(2*p)*LW   +: LW];
    assign oddVec [(2*p)*LW   +: LW] = opA[(2*p+1)*LW +: LW];
    assign oddVec [(2*p+1)*LW +: LW] = opB[(2*p+1)*LW +: LW];
  end

  // Vertical stage: lane-wise add with carries discarded; A sums go to the
  // lower half, B sums to the upper half.
  for (genvar p = 0; p < HALF; p++) begin : g_add
    assign sumVec[p*LW +: LW] =
      evenVec[(2*p)*LW +: LW] + oddVec[(2*p)*LW +: LW];
    assign sumVec[(HALF+p)*LW +: LW] =
      evenVec[(2*p+1)*LW +: LW] + oddVec[(2*p+1)*LW +: LW];
  end

  always_comb begin
    nextLo = ctl.sumSel ? sumVec : evenVec;
    nextHi = ctl.sumSel ? '0     : oddVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLo <= '0;
      outHi <= '0;
    end else if (ctl.capture) begin
      outLo <= nextLo;
      outHi <= nextHi;
    end
  end

  AST_HOLD_LO: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(outLo)); // R8
  AST_HOLD_HI: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(outHi)); // R8
  AST_HI_ZERO_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.sumSel) |=> (outHi == '0)); // R5
  AST_LANE0_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.sumSel) |=>
      (outLo[LW-1:0] == LW'($past(opA[LW-1:0]) + $past(opA[2*LW-1:LW])))); // R3
  AST_SHUF_B0: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.sumSel) |=>
      (outLo[2*LW-1:LW] == $past(opB[LW-1:0]))); // R6
endmodule

// File: rtl/hadd_pair_top.sv
module hadd_pair_top
  import hadd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             modeShuf,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic             outValid,
  output logic [VEC_W-1:0] outLo,
  output logic [VEC_W-1:0] outHi
);
  haddCtl_t ctl;

  hadd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeShuf(modeShuf),
    .ctl(ctl), .outValid(outValid)
  );

  hadd_datapath #(.NLANE(LANES), .LW(LANE_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(opA), .opB(opB),
    .outLo(outLo), .outHi(outHi)
  );
endmodule

// File: tb/test_hadd_pair_top.sv
module test_hadd_pair_top;
  import hadd_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, inValid = 0, modeShuf = 0;
  logic [VEC_W-1:0] opA = '0, opB = '0;
  logic outValid;
  logic [VEC_W-1:0] outLo, outHi;
  int nChk = 0, nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hadd_pair_top i_hadd_pair_top (.*);

  function automatic logic [VEC_W-1:0] modelLo(input logic m,
      input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    logic [VEC_W-1:0] r = '0;
    for (int k = 0; k < LANES/2; k++) begin
      if (!m) begin
        r[k*16 +: 16] = a[(2*k)*16 +: 16] + a[(2*k+1)*16 +: 16];
        r[(LANES/2+k)*16 +: 16] = b[(2*k)*16 +: 16] + b[(2*k+1)*16 +: 16];
      end else begin
        r[(2*k)*16 +: 16] = a[(2*k)*16 +: 16];
        r[(2*k+1)*16 +: 16] = b[(2*k)*16 +: 16];
      end
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] modelHi(input logic m,
      input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    logic [VEC_W-1:0] r = '0;
    if (m)
      for (int k = 0; k < LANES/2; k++) begin
        r[(2*k)*16 +: 16] = a[(2*k+1)*16 +: 16];
        r[(2*k+1)*16 +: 16] = b[(2*k+1)*16 +: 16];
      end
    return r;
  endfunction

  task automatic check(input string req, input logic [VEC_W-1:0] act,
      input logic [VEC_W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Apply one operation, then sample mid-cycle after the capturing edge.
  task automatic apply(input logic m, input logic [VEC_W-1:0] a,
      input logic [VEC_W-1:0] b, input string tag);
    @(negedge clk);
    inValid = 1; modeShuf = m; opA = a; opB = b;
    @(negedge clk);
    inValid = 0;
    check({tag, " R2 valid"}, {127'b0, outValid}, 128'd1);
    if (!m) begin
      check({tag, " R3/R4 lo"}, outLo, modelLo(m, a, b));
      check({tag, " R5 hi"}, outHi, modelHi(m, a, b));
    end else begin
      check({tag, " R6 lo"}, outLo, modelLo(m, a, b));
      check({tag, " R7 hi"}, outHi, modelHi(m, a, b));
    end
  endtask

  function automatic logic [VEC_W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD*5000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [VEC_W-1:0] holdLo, holdHi, lane;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid", {127'b0, outValid}, '0);
    check("R1 lo", outLo, '0);
    check("R1 hi", outHi, '0);
    rstN = 1;

    // R3/R4 directed: a carry out of every lane must be dropped
    apply(0, {LANES{16'hFFFF}}, {LANES{16'h8000}}, "allones");
    apply(0, {LANES{16'h0001}}, {LANES{16'h7FFF}}, "small");
    for (int k = 0; k < LANES; k++) lane[k*16 +: 16] = 16'(k + 1);
    apply(0, lane, ~lane, "ramp");
    apply(1, lane, ~lane, "ramp_shuf");
    apply(1, {LANES{16'hFFFF}}, '0, "shuf_ones");

    for (int i = 0; i < 60; i++) apply(1'($urandom), rnd(), rnd(), "random");

    // R8: idle cycles with busy operands must not touch the outputs
    holdLo = outLo; holdHi = outHi;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid = 0; modeShuf = ~modeShuf; opA = rnd(); opB = rnd();
    end
    @(negedge clk);
    check("R8 lo hold", outLo, holdLo);
    check("R8 hi hold", outHi, holdHi);
    check("R2 idle valid", {127'b0, outValid}, '0);

    // R2: back-to-back valid stays high
    @(negedge clk); inValid = 1; modeShuf = 0; opA = rnd(); opB = rnd();
    @(negedge clk); opA = rnd();
    check("R2 b2b", {127'b0, outValid}, 128'd1);
    @(negedge clk);
    inValid = 0;
    check("R2 b2b2", {127'b0, outValid}, 128'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule